// File: doc/BRIEF.md
# I2C Master Start-Condition Controller

This block turns a software request for a START into correct activity on an open-drain two-wire bus. It watches the synchronised SDA and SCL lines to keep a bus-busy flag. When a request is written, the block acts on the bus state and its own role. If the bus is idle, it issues a START at once and becomes master. If it is master and parked in the wait state, it issues a repeated START. If another master holds the bus, it either keeps the request pending until that master releases the bus or refuses it and raises a rejection flag. A reservation-disable input picks between those last two behaviours.

The neighbouring byte engine, acknowledge logic and stop generator talk to it only through four handshake inputs: the interface enable, the master wait state, arbitration loss and exit from communication. The START waveform is timed by a programmable count of clock cycles per half SCL period. The pending-request bit, the rejection flag, the busy flag and the master flag are outputs for a register interface to read.

Once the clock-low phase of a START ends, the block releases both lines. The byte engine is expected to hold SCL from that point on.

Top module: `i2c_start_ctrl`

## Requirements
- R1: After reset, both line pulls, the pending bit, the rejection flag, the busy flag and the master flag are all 0.
- R2: The busy flag becomes 1 within four clock cycles of SDA falling while SCL is high. It becomes 0 within four cycles of SDA rising while SCL is high. SDA edges while SCL is low leave it unchanged.
- R3: A request written while the bus is not busy pulls SDA low with SCL released for exactly HALF_CNT cycles, then holds both lines low for HALF_CNT cycles. After that the pending bit reads 0 and the master flag reads 1.
- R4: A request written while the bus is busy and reservation is enabled (resv_off = 0) sets the pending bit and drives nothing. When a STOP is then seen, the START of R3 follows on its own.
- R5: A request written while the bus is busy and resv_off = 1 leaves the pending bit at 0, sets the rejection flag and drives nothing.
- R6: The rejection flag stays 1 until a rej_clr_wr pulse or reset clears it.
- R7: A request written while master with mst_wait = 1 produces a repeated START in four phases of HALF_CNT cycles each: SCL low with SDA released, both released, SDA low with SCL released, both low. The block stays master.
- R8: A request written while master with mst_wait = 0 is ignored: the pending bit stays 0 and nothing is driven.
- R9: A request written in the same cycle as req_stop_wr is ignored: the pending bit stays 0 and nothing is driven.
- R10: While iface_en = 0, requests are ignored. Dropping iface_en clears the pending bit (a pending reservation is lost), the busy flag and the master flag, and releases both lines in the next cycle.
- R11: arb_lost or exit_comm clears the pending bit and the master flag. A reservation dropped this way does not fire on the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable |
| resv_off | input | 1 | 1 = refuse requests while the bus is busy; 0 = reserve them |
| req_start_wr | input | 1 | One-cycle write of 1 to the START request bit |
| req_stop_wr | input | 1 | One-cycle write of a STOP request in the same register write |
| rej_clr_wr | input | 1 | One-cycle write clearing the rejection flag |
| mst_wait | input | 1 | Byte engine is master and holding the wait state |
| arb_lost | input | 1 | Arbitration lost pulse |
| exit_comm | input | 1 | Exit-from-communication pulse |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_pull | output | 1 | 1 = pull SDA low (open drain) |
| scl_pull | output | 1 | 1 = pull SCL low (open drain) |
| start_pend | output | 1 | START request bit (pending or in progress) |
| start_rejected | output | 1 | Request refused while bus busy |
| bus_busy | output | 1 | Bus busy flag |
| is_master | output | 1 | Block holds the bus as master |

## Verification
The hardest state to reach is a reservation that has been dropped. To get there, the bench must first let another master seize the bus, then write a request so that it becomes pending, then clear it through exit_comm or the enable. Only after that does it produce the STOP that would have fired the reservation. The bench drives its own open-drain contributions onto modelled SDA and SCL lines, so it can play the other master, and then checks that no pull appears after the STOP. The repeated START is reached the same way: a real START first makes the block master, and the bench then holds SCL low while raising the wait input.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RS_SDA,
    SQ_RS_SCL,
    SQ_HOLD,
    SQ_LOW
  } sq_state_e;

  // {sda_pull, scl_pull} for each sequencer state
  function automatic logic [1:0] pulls_of(sq_state_e s);
    case (s)
      SQ_RS_SDA: pulls_of = 2'b01;
      SQ_RS_SCL: pulls_of = 2'b00;
      SQ_HOLD:   pulls_of = 2'b10;
      SQ_LOW:    pulls_of = 2'b11;
      default:   pulls_of = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sda_i,
  input  logic scl_i,
  output logic bus_busy,
  output logic start_seen,
  output logic stop_seen
);
  localparam int LINES = 2;
  localparam int TOP   = SYNC_STAGES - 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '1;
      else     sr <= {sr[SYNC_STAGES-2:0], raw[g]};
    end
    assign now[g] = sr[TOP];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= now;
  end

  // index 0 = SDA, 1 = SCL; SCL must be high on both samples
  always_comb begin
    start_seen = prev[0] & ~now[0] & prev[1] & now[1];
    stop_seen  = ~prev[0] & now[0] & prev[1] & now[1];
  end

  always_ff @(posedge clk) begin
    if (rst || !en)      bus_busy <= 1'b0;
    else if (start_seen) bus_busy <= 1'b1;
    else if (stop_seen)  bus_busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_start_pkg::*;
#(
  parameter int HALF_CNT = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic go_start,
  input  logic go_rs,
  output logic sda_pull,
  output logic scl_pull,
  output logic seq_idle,
  output logic seq_done
);
  localparam int CNT_W = (HALF_CNT < 2) ? 1 : $clog2(HALF_CNT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CNT - 1);

  sq_state_e        state, state_n;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = (cnt == LAST);
  assign seq_idle = (state == SQ_IDLE);
  assign seq_done = (state == SQ_LOW) && last && !abort;

  always_comb begin
    state_n = state;
    case (state)
      SQ_IDLE: begin
        if (go_rs)         state_n = SQ_RS_SDA;
        else if (go_start) state_n = SQ_HOLD;
      end
      SQ_RS_SDA: if (last) state_n = SQ_RS_SCL;
      SQ_RS_SCL: if (last) state_n = SQ_HOLD;
      SQ_HOLD:   if (last) state_n = SQ_LOW;
      SQ_LOW:    if (last) state_n = SQ_IDLE;
      default:   state_n = SQ_IDLE;
    endcase
    if (abort) state_n = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
      scl_pull <= 1'b0;
    end else begin
      state <= state_n;
      if (state_n != state || state_n == SQ_IDLE) cnt <= '0;
      else                                        cnt <= cnt + 1'b1;
      {sda_pull, scl_pull} <= pulls_of(state_n);
    end
  end
endmodule

// File: rtl/i2c_start_req.sv
module i2c_start_req (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic abort,
  input  logic start_wr,
  input  logic stop_wr,
  input  logic rej_clr,
  input  logic resv_off,
  input  logic mst_wait,
  input  logic bus_busy,
  input  logic stop_seen,
  input  logic seq_idle,
  input  logic seq_done,
  output logic start_pend,
  output logic start_rejected,
  output logic is_master,
  output logic go_start,
  output logic go_rs
);
  logic rs_mode;
  logic accept;

  assign accept = start_wr && !stop_wr && !start_pend;

  always_comb begin
    go_start = start_pend && !rs_mode && seq_idle && !bus_busy && !is_master && !abort;
    go_rs    = start_pend && rs_mode && seq_idle && is_master && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pend     <= 1'b0;
      start_rejected <= 1'b0;
      is_master      <= 1'b0;
      rs_mode        <= 1'b0;
    end else begin
      if (rej_clr) start_rejected <= 1'b0;
      if (abort) begin
        start_pend <= 1'b0;
        is_master  <= 1'b0;
        rs_mode    <= 1'b0;
      end else begin
        if (stop_seen) is_master <= 1'b0;
        if (seq_done) begin
          start_pend <= 1'b0;
          is_master  <= 1'b1;
          rs_mode    <= 1'b0;
        end
        if (accept) begin
          if (is_master) begin
            if (mst_wait) begin
              start_pend <= 1'b1;
              rs_mode    <= 1'b1;
            end
          end else if (!bus_busy || !resv_off) begin
            start_pend <= 1'b1;
            rs_mode    <= 1'b0;
          end else begin
            start_rejected <= 1'b1;
          end
        end
      end
    end
  end

  // en is folded into abort at the top; kept as a port for clarity of use
  logic unused_en;
  assign unused_en = en;
endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl #(
  parameter int HALF_CNT    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic iface_en,
  input  logic resv_off,
  input  logic req_start_wr,
  input  logic req_stop_wr,
  input  logic rej_clr_wr,
  input  logic mst_wait,
  input  logic arb_lost,
  input  logic exit_comm,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_pull,
  output logic scl_pull,
  output logic start_pend,
  output logic start_rejected,
  output logic bus_busy,
  output logic is_master
);
  logic abort, start_seen, stop_seen;
  logic go_start, go_rs, seq_idle, seq_done;

  assign abort = !iface_en || arb_lost || exit_comm;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .en(iface_en), .sda_i(sda_i), .scl_i(scl_i),
    .bus_busy(bus_busy), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2c_start_req u_req (
    .clk(clk), .rst(rst), .en(iface_en), .abort(abort),
    .start_wr(req_start_wr), .stop_wr(req_stop_wr), .rej_clr(rej_clr_wr),
    .resv_off(resv_off), .mst_wait(mst_wait), .bus_busy(bus_busy),
    .stop_seen(stop_seen), .seq_idle(seq_idle), .seq_done(seq_done),
    .start_pend(start_pend), .start_rejected(start_rejected),
    .is_master(is_master), .go_start(go_start), .go_rs(go_rs)
  );

  i2c_start_seq #(.HALF_CNT(HALF_CNT)) u_seq (
    .clk(clk), .rst(rst), .abort(abort), .go_start(go_start), .go_rs(go_rs),
    .sda_pull(sda_pull), .scl_pull(scl_pull),
    .seq_idle(seq_idle), .seq_done(seq_done)
  );

  logic unused_start;
  assign unused_start = start_seen;
endmodule

// File: rtl/i2c_start_ctrl_chk.sv
module i2c_start_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic iface_en,
  input logic resv_off,
  input logic req_start_wr,
  input logic req_stop_wr,
  input logic rej_clr_wr,
  input logic mst_wait,
  input logic arb_lost,
  input logic exit_comm,
  input logic sda_pull,
  input logic scl_pull,
  input logic start_pend,
  input logic start_rejected,
  input logic bus_busy,
  input logic is_master
);
  a_r3_clock_after_data: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_pull) && sda_pull) |-> $past(sda_pull));

  a_r5_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    (req_start_wr && !req_stop_wr && iface_en && !arb_lost && !exit_comm &&
     !start_pend && bus_busy && !is_master && resv_off)
    |=> (start_rejected && !start_pend));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (start_rejected && !rej_clr_wr) |=> start_rejected);

  a_r8_no_start_mid_transfer: assert property (@(posedge clk) disable iff (rst)
    (req_start_wr && is_master && !mst_wait && !start_pend) |=> !start_pend);

  a_r9_start_with_stop: assert property (@(posedge clk) disable iff (rst)
    (req_start_wr && req_stop_wr && !start_pend) |=> !start_pend);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !iface_en |=> (!start_pend && !sda_pull && !scl_pull && !bus_busy && !is_master));

  a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
    (arb_lost || exit_comm) |=> (!start_pend && !is_master));
endmodule

bind i2c_start_ctrl i2c_start_ctrl_chk u_chk (.*);

// File: tb/i2c_start_ctrl_bench.sv
module i2c_start_ctrl_bench;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iface_en = 1'b0, resv_off = 1'b0, req_start_wr = 1'b0, req_stop_wr = 1'b0;
  logic rej_clr_wr = 1'b0, mst_wait = 1'b0, arb_lost = 1'b0, exit_comm = 1'b0;
  logic ext_sda_lo = 1'b0, ext_scl_lo = 1'b0;
  logic sda_pull, scl_pull, start_pend, start_rejected, bus_busy, is_master;
  logic sda_line, scl_line;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = !(sda_pull || ext_sda_lo);
  assign scl_line = !(scl_pull || ext_scl_lo);

  i2c_start_ctrl #(.HALF_CNT(HALF), .SYNC_STAGES(2)) u_i2c_start_ctrl (
    .clk(clk), .rst(rst), .iface_en(iface_en), .resv_off(resv_off),
    .req_start_wr(req_start_wr), .req_stop_wr(req_stop_wr), .rej_clr_wr(rej_clr_wr),
    .mst_wait(mst_wait), .arb_lost(arb_lost), .exit_comm(exit_comm),
    .sda_i(sda_line), .scl_i(scl_line), .sda_pull(sda_pull), .scl_pull(scl_pull),
    .start_pend(start_pend), .start_rejected(start_rejected),
    .bus_busy(bus_busy), .is_master(is_master)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iface_en = 1'b1; mst_wait = 1'b0;
    ext_sda_lo = 1'b0; ext_scl_lo = 1'b0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
  endtask

  task automatic pulse_start(input logic with_stop);
    req_start_wr = 1'b1; req_stop_wr = with_stop;
    @(negedge clk);
    req_start_wr = 1'b0; req_stop_wr = 1'b0;
  endtask

  task automatic watch(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sda_pull || scl_pull) hits++;
    end
  endtask

  // START: waits for SDA pull, measures data-low and both-low phases
  task automatic meas_start(output int seen, output int hold, output int low);
    seen = 0; hold = 0; low = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (sda_pull) seen = 1;
    end
    for (int i = 0; i < 40 && sda_pull && !scl_pull; i++) begin hold++; @(negedge clk); end
    for (int i = 0; i < 40 && sda_pull && scl_pull; i++)  begin low++;  @(negedge clk); end
  endtask

  task automatic meas_rs(output int p1, output int p2, output int p3, output int p4);
    int seen;
    seen = 0; p1 = 0; p2 = 0; p3 = 0; p4 = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (scl_pull && !sda_pull) seen = 1;
    end
    ext_scl_lo = 1'b0;
    for (int i = 0; i < 40 && scl_pull && !sda_pull; i++)  begin p1++; @(negedge clk); end
    for (int i = 0; i < 40 && !scl_pull && !sda_pull; i++) begin p2++; @(negedge clk); end
    for (int i = 0; i < 40 && sda_pull && !scl_pull; i++)  begin p3++; @(negedge clk); end
    for (int i = 0; i < 40 && sda_pull && scl_pull; i++)   begin p4++; @(negedge clk); end
  endtask

  initial begin
    int seen, hold, low, hits, p1, p2, p3, p4;
    do_reset();
    // R1
    chk("R1 sda_pull", sda_pull, 0);   chk("R1 scl_pull", scl_pull, 0);
    chk("R1 start_pend", start_pend, 0); chk("R1 rejected", start_rejected, 0);
    chk("R1 busy", bus_busy, 0);       chk("R1 master", is_master, 0);

    // R2: START / STOP on bus, then SDA edges with SCL low
    ext_sda_lo = 1'b1; cycles(4); chk("R2 busy after start", bus_busy, 1);
    ext_sda_lo = 1'b0; cycles(4); chk("R2 idle after stop", bus_busy, 0);
    ext_scl_lo = 1'b1; cycles(4); ext_sda_lo = 1'b1; cycles(4);
    chk("R2 sda fall scl low", bus_busy, 0);
    ext_sda_lo = 1'b0; cycles(4); ext_scl_lo = 1'b0; cycles(4);
    chk("R2 sda rise scl low", bus_busy, 0);

    // sweep: reservation setting x bus state
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 2; b++) begin
        do_reset();
        resv_off = r[0];
        if (b != 0) begin ext_sda_lo = 1'b1; cycles(4); end
        pulse_start(1'b0);
        if (b == 0) begin
          meas_start(seen, hold, low);
          chk("R3 start issued", seen, 1);
          chk("R3 data-low phase", hold, HALF);
          chk("R3 both-low phase", low, HALF);
          chk("R3 pend cleared", start_pend, 0);
          chk("R3 master", is_master, 1);
          chk("R3 busy", bus_busy, 1);
        end else if (r == 0) begin
          chk("R4 reserved", start_pend, 1);
          chk("R4 no reject", start_rejected, 0);
          watch(10, hits); chk("R4 no drive while busy", hits, 0);
          ext_sda_lo = 1'b0;
          meas_start(seen, hold, low);
          chk("R4 fires after stop", seen, 1);
          chk("R4 data-low phase", hold, HALF);
          chk("R4 both-low phase", low, HALF);
          chk("R4 master", is_master, 1);
        end else begin
          chk("R5 pend stays 0", start_pend, 0);
          chk("R5 rejected", start_rejected, 1);
          watch(10, hits); chk("R5 no drive", hits, 0);
          chk("R6 flag holds", start_rejected, 1);
          rej_clr_wr = 1'b1; @(negedge clk); rej_clr_wr = 1'b0;
          chk("R6 flag cleared", start_rejected, 0);
        end
      end
    end

    // R8 then R7: become master first
    do_reset(); resv_off = 1'b0;
    pulse_start(1'b0);
    meas_start(seen, hold, low);
    chk("R3 setup master", is_master, 1);
    pulse_start(1'b0);
    chk("R8 ignored outside wait", start_pend, 0);
    watch(10, hits); chk("R8 no drive", hits, 0);
    mst_wait = 1'b1; ext_scl_lo = 1'b1; cycles(2);
    pulse_start(1'b0);
    chk("R7 request taken", start_pend, 1);
    mst_wait = 1'b0;
    meas_rs(p1, p2, p3, p4);
    chk("R7 phase clock low", p1, HALF);
    chk("R7 phase released", p2, HALF);
    chk("R7 phase data low", p3, HALF);
    chk("R7 phase both low", p4, HALF);
    chk("R7 still master", is_master, 1);
    chk("R7 pend cleared", start_pend, 0);
    chk("R7 busy", bus_busy, 1);

    // R11: arbitration loss, then dropped reservation via exit
    arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    chk("R11 arb clears master", is_master, 0);
    pulse_start(1'b0);
    chk("R11 setup reservation", start_pend, 1);
    exit_comm = 1'b1; @(negedge clk); exit_comm = 1'b0;
    chk("R11 exit clears pend", start_pend, 0);
    ext_sda_lo = 1'b1; cycles(4); ext_sda_lo = 1'b0;
    watch(12, hits); chk("R11 dropped reservation silent", hits, 0);
    chk("R11 bus idle", bus_busy, 0);

    // R9: start with stop in same write
    pulse_start(1'b1);
    chk("R9 pend stays 0", start_pend, 0);
    watch(10, hits); chk("R9 no drive", hits, 0);

    // R10: disable drops reservation, blocks requests, aborts a sequence
    ext_sda_lo = 1'b1; cycles(4);
    pulse_start(1'b0);
    chk("R10 setup reservation", start_pend, 1);
    iface_en = 1'b0; @(negedge clk);
    chk("R10 pend dropped", start_pend, 0);
    chk("R10 busy cleared", bus_busy, 0);
    iface_en = 1'b1; cycles(2); ext_sda_lo = 1'b0;
    watch(12, hits); chk("R10 no fire after stop", hits, 0);
    iface_en = 1'b0; cycles(1);
    pulse_start(1'b0);
    chk("R10 ignored while off", start_pend, 0);
    watch(6, hits); chk("R10 no drive while off", hits, 0);
    iface_en = 1'b1; cycles(2);
    pulse_start(1'b0); cycles(2);
    chk("R10 sequence running", sda_pull, 1);
    iface_en = 1'b0; @(negedge clk);
    chk("R10 sda released", sda_pull, 0);
    chk("R10 master cleared", is_master, 0);
    iface_en = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule